// File: doc/BRIEF.md
# Wiper Position Counter with One-Hot Tap Select

This block keeps the volatile position of a digitally controlled potentiometer wiper and turns it into the enable pattern for the tap switches of the resistor chain. The position is a small binary counter. It can be overwritten by a value recalled at power-up, by a value copied from one of the stored data registers, or by a value the host sends directly. The host can also nudge it up or down one tap at a time.

A protocol front end, which is not part of this block, raises at most a few request strobes per clock. The block picks one winner by fixed priority and updates the counter. In the same clock edge it also updates a registered one-hot tap-select vector. Code zero connects the wiper to the low-end terminal tap. The all-ones code connects it to the high-end terminal tap. Steps saturate at both ends and never wrap. The binary position is brought out for readback.

Top module: `wiper_tap_top`

## Requirements
- R1: While reset is asserted and after its release with no request, `wiperPos` is 0 and `tapSel` has only bit 0 set.
- R2: A cycle with `recallEn` high loads `recallData` into `wiperPos`, visible after the next rising clock edge.
- R3: A cycle with `parEn` high and `recallEn` low loads `parData`, visible after the next edge.
- R4: A cycle with `serEn` high and neither `recallEn` nor `parEn` high loads `serData`, visible after the next edge.
- R5: A cycle with `stepEn` high and no load request adds one to the position when `stepUp` is 1, or subtracts one when `stepUp` is 0.
- R6: An up step at the all-ones code, or a down step at code 0, leaves the position unchanged. There is no wraparound.
- R7: When several requests coincide, only the highest-priority one is applied, in the order recall, parallel load, serial load, step. Exactly one update takes effect per clock.
- R8: `tapSel` always has exactly one bit set, and that bit's index equals `wiperPos`. Bit 0 is the low-end terminal tap and bit 2^WIDTH-1 is the high-end terminal tap. Both outputs change on the same edge.
- R9: In a cycle with no request enable high, the position holds, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| recallEn | input | 1 | Power-up recall request (supplies valid) |
| recallData | input | WIDTH | Content of stored data register 0 |
| parEn | input | 1 | Parallel load from a selected data register |
| parData | input | WIDTH | Content of the selected data register |
| serEn | input | 1 | Direct host write of the position |
| serData | input | WIDTH | Value received from the host |
| stepEn | input | 1 | Single-step request |
| stepUp | input | 1 | Step direction: 1 toward high terminal, 0 toward low terminal |
| wiperPos | output | WIDTH | Current position for readback |
| tapSel | output | 2^WIDTH | Registered one-hot tap switch enables |

## Verification
The assertions watch four things every cycle: the one-hot shape of `tapSel` and its agreement with `wiperPos`, the mutual exclusion of the internal update strobes, and the next-cycle effect of each request class, including saturation at both ends and holding when idle. The bench scenarios cover what needs an outside reference. They show the reset state, walk the counter across both terminal codes, and apply every combination of coinciding requests that settles the priority order. They also toggle the data buses with no enable high to show that nothing leaks through.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int WIPER_W = 6;

  // Update strobes from control to datapath; at most one is high.
  typedef struct packed {
    logic loadRecall;
    logic loadPar;
    logic loadSer;
    logic stepInc;
    logic stepDec;
  } wiperStb_t;
endpackage

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
(
  input  logic      recallEn,
  input  logic      parEn,
  input  logic      serEn,
  input  logic      stepEn,
  input  logic      stepUp,
  output wiperStb_t stb
);
  always_comb begin
    stb = '0;
    if (recallEn)      stb.loadRecall = 1'b1;
    else if (parEn)    stb.loadPar    = 1'b1;
    else if (serEn)    stb.loadSer    = 1'b1;
    else if (stepEn) begin
      if (stepUp)      stb.stepInc    = 1'b1;
      else             stb.stepDec    = 1'b1;
    end
  end
endmodule

// File: rtl/wiper_dpath.sv
module wiper_dpath
  import wiper_pkg::*;
#(
  parameter int WIDTH = WIPER_W,
  localparam int TAPS = 1 << WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  wiperStb_t        stb,
  input  logic [WIDTH-1:0] recallData,
  input  logic [WIDTH-1:0] parData,
  input  logic [WIDTH-1:0] serData,
  output logic [WIDTH-1:0] wiperPos,
  output logic [TAPS-1:0]  tapSel
);
  localparam logic [WIDTH-1:0] TOP_CODE = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT_CODE = '0;

  logic [WIDTH-1:0] posQ, posNext;
  logic [TAPS-1:0]  tapQ, tapNext;

  always_comb begin
    posNext = posQ;
    if (stb.loadRecall)   posNext = recallData;
    else if (stb.loadPar) posNext = parData;
    else if (stb.loadSer) posNext = serData;
    else if (stb.stepInc && (posQ != TOP_CODE)) posNext = posQ + 1'b1;
    else if (stb.stepDec && (posQ != BOT_CODE)) posNext = posQ - 1'b1;
  end

  // Decode the next code so the tap register moves on the same edge.
  for (genvar g = 0; g < TAPS; g++) begin : g_tapDec
    assign tapNext[g] = (posNext == WIDTH'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ <= BOT_CODE;
      tapQ <= TAPS'(1);
    end else begin
      posQ <= posNext;
      tapQ <= tapNext;
    end
  end

  assign wiperPos = posQ;
  assign tapSel   = tapQ;
endmodule

// File: rtl/wiper_tap_top.sv
module wiper_tap_top
  import wiper_pkg::*;
#(
  parameter int WIDTH = WIPER_W,
  localparam int TAPS = 1 << WIDTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             recallEn,
  input  logic [WIDTH-1:0] recallData,
  input  logic             parEn,
  input  logic [WIDTH-1:0] parData,
  input  logic             serEn,
  input  logic [WIDTH-1:0] serData,
  input  logic             stepEn,
  input  logic             stepUp,
  output logic [WIDTH-1:0] wiperPos,
  output logic [TAPS-1:0]  tapSel
);
  wiperStb_t ctrlStb;

  wiper_ctrl ctrl_i (
    .recallEn (recallEn),
    .parEn    (parEn),
    .serEn    (serEn),
    .stepEn   (stepEn),
    .stepUp   (stepUp),
    .stb      (ctrlStb)
  );

  wiper_dpath #(.WIDTH(WIDTH)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (ctrlStb),
    .recallData (recallData),
    .parData    (parData),
    .serData    (serData),
    .wiperPos   (wiperPos),
    .tapSel     (tapSel)
  );
endmodule

// File: rtl/wiper_tap_chk.sv
module wiper_tap_chk #(
  parameter int WIDTH = 6,
  localparam int TAPS = 1 << WIDTH
) (
  input logic             clk,
  input logic             rstN,
  input logic             recallEn,
  input logic [WIDTH-1:0] recallData,
  input logic             parEn,
  input logic [WIDTH-1:0] parData,
  input logic             serEn,
  input logic [WIDTH-1:0] serData,
  input logic             stepEn,
  input logic             stepUp,
  input logic [WIDTH-1:0] wiperPos,
  input logic [TAPS-1:0]  tapSel,
  input logic [4:0]       stbBits
);
  localparam logic [WIDTH-1:0] TOP_CODE = {WIDTH{1'b1}};
  logic noLoad;
  assign noLoad = !recallEn && !parEn && !serEn;

  assert_tap_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(tapSel));
  assert_tap_matches_pos_R8: assert property (@(posedge clk) disable iff (!rstN)
    tapSel[wiperPos] == 1'b1);
  assert_single_update_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stbBits));
  assert_recall_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    recallEn |=> wiperPos == $past(recallData));
  assert_par_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (parEn && !recallEn) |=> wiperPos == $past(parData));
  assert_ser_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (serEn && !parEn && !recallEn) |=> wiperPos == $past(serData));
  assert_step_up_R5: assert property (@(posedge clk) disable iff (!rstN)
    (noLoad && stepEn && stepUp && wiperPos != TOP_CODE)
      |=> wiperPos == WIDTH'($past(wiperPos) + 1'b1));
  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rstN)
    (noLoad && stepEn && !stepUp && wiperPos != '0)
      |=> wiperPos == WIDTH'($past(wiperPos) - 1'b1));
  assert_no_wrap_top_R6: assert property (@(posedge clk) disable iff (!rstN)
    (noLoad && stepEn && stepUp && wiperPos == TOP_CODE) |=> wiperPos == TOP_CODE);
  assert_no_wrap_bottom_R6: assert property (@(posedge clk) disable iff (!rstN)
    (noLoad && stepEn && !stepUp && wiperPos == '0) |=> wiperPos == '0);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (noLoad && !stepEn) |=> $stable(wiperPos));
endmodule

bind wiper_tap_top wiper_tap_chk #(.WIDTH(WIDTH)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .recallEn   (recallEn),
  .recallData (recallData),
  .parEn      (parEn),
  .parData    (parData),
  .serEn      (serEn),
  .serData    (serData),
  .stepEn     (stepEn),
  .stepUp     (stepUp),
  .wiperPos   (wiperPos),
  .tapSel     (tapSel),
  .stbBits    (ctrlStb)
);

// File: tb/wiper_tap_top_tb_top.sv
module wiper_tap_top_tb_top;
  localparam int W = 6;
  localparam int T = 1 << W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic recallEn = 1'b0, parEn = 1'b0, serEn = 1'b0, stepEn = 1'b0, stepUp = 1'b0;
  logic [W-1:0] recallData = '0, parData = '0, serData = '0;
  logic [W-1:0] wiperPos;
  logic [T-1:0] tapSel;

  int vecCnt = 0;
  int errCnt = 0;
  logic [W-1:0] model = '0;
  logic [W-1:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  wiper_tap_top #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN),
    .recallEn(recallEn), .recallData(recallData),
    .parEn(parEn), .parData(parData),
    .serEn(serEn), .serData(serData),
    .stepEn(stepEn), .stepUp(stepUp),
    .wiperPos(wiperPos), .tapSel(tapSel)
  );

  task automatic checkOut(string tag, logic [W-1:0] exp);
    vecCnt++;
    if (wiperPos !== exp || tapSel !== (T'(1) << exp)) begin
      errCnt++;
      $display("FAIL %s: pos=%h tap=%h expected pos=%h tap=%h",
               tag, wiperPos, tapSel, exp, T'(1) << exp);
    end
  endtask

  // Driver: applies one request pattern and queues the expected position.
  task automatic applyVec(string tag, logic rc, logic [W-1:0] rd, logic pe,
                          logic [W-1:0] pd, logic se, logic [W-1:0] sd,
                          logic st, logic up);
    @(negedge clk);
    recallEn = rc; recallData = rd; parEn = pe; parData = pd;
    serEn = se; serData = sd; stepEn = st; stepUp = up;
    if (rc)      model = rd;
    else if (pe) model = pd;
    else if (se) model = sd;
    else if (st && up && model != {W{1'b1}}) model = model + 1'b1;
    else if (st && !up && model != '0)       model = model - 1'b1;
    expQ.push_back(model);
    tagQ.push_back(tag);
  endtask

  // Monitor: compares after each update edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) checkOut(tagQ.pop_front(), expQ.pop_front());
    end
  end

  initial begin
    #20000;
    errCnt++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    checkOut("R1 during reset", '0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after release", '0);

    applyVec("R2 recall",            1, 6'h2A, 0, 6'h00, 0, 6'h00, 0, 0);
    applyVec("R9 idle hold",         0, 6'h11, 0, 6'h22, 0, 6'h33, 0, 1);
    applyVec("R5 step up",           0, 6'h00, 0, 6'h00, 0, 6'h00, 1, 1);
    applyVec("R5 step down",         0, 6'h00, 0, 6'h00, 0, 6'h00, 1, 0);
    applyVec("R5 step down again",   0, 6'h00, 0, 6'h00, 0, 6'h00, 1, 0);
    applyVec("R3 parallel load",     0, 6'h00, 1, 6'h3E, 0, 6'h00, 0, 0);
    applyVec("R8 reach high tap",    0, 6'h00, 0, 6'h00, 0, 6'h00, 1, 1);
    applyVec("R6 saturate high",     0, 6'h00, 0, 6'h00, 0, 6'h00, 1, 1);
    applyVec("R4 serial load zero",  0, 6'h00, 0, 6'h00, 1, 6'h00, 0, 0);
    applyVec("R6 saturate low",      0, 6'h00, 0, 6'h00, 0, 6'h00, 1, 0);
    applyVec("R7 recall wins",       1, 6'h15, 1, 6'h2B, 1, 6'h07, 1, 1);
    applyVec("R7 parallel wins",     0, 6'h3F, 1, 6'h09, 1, 6'h31, 1, 0);
    applyVec("R7 serial wins",       0, 6'h3F, 0, 6'h01, 1, 6'h24, 1, 1);
    applyVec("R9 data toggles only", 0, 6'h3F, 0, 6'h3F, 0, 6'h3F, 0, 0);
    applyVec("R4 serial load mid",   0, 6'h00, 0, 6'h00, 1, 6'h20, 0, 0);
    applyVec("R9 idle after load",   0, 6'h00, 0, 6'h00, 0, 6'h00, 0, 0);

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      errCnt++;
      $display("FAIL R7: %0d results missing, expected 0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule